// File: doc/BRIEF.md
# Sync-Framed Nibble-to-Word Assembler

This block rebuilds signed 10-bit transmit samples that arrive two halves at a time on a 6-bit nibble bus. Nibbles are sampled on the rising edge of a clock that runs at twice the word rate. A level-sensitive framing strobe marks each nibble's place in its word. A nibble taken while the strobe is low is the high part. The nibble taken with the strobe high on the following cycle is the low part. Each time a pair completes, the block presents the assembled word to the downstream interpolation stage with a one-cycle valid pulse.

When the strobe stays low across several cycles, the block keeps delivering the last completed word. It pulses valid once per word period until a high-strobe nibble completes a new word, which lets the sender flush the interpolator with a repeated value. An enable input gates the data output: while enable is low the word output reads zero, but the held word and the valid pulses are kept.

Top module: `nib_word_asm`

## Requirements
- R1: Each nibble contributes its bits 5:1. The high-part nibble (strobe low) fills word bits 9:5 and the low-part nibble (strobe high, next cycle) fills bits 4:0. The result is on `word_o` after the clock edge that samples the low-part nibble.
- R2: `word_vld_o` is high for exactly one cycle after the edge that completes a low-strobe/high-strobe pair.
- R3: A high-strobe nibble that does not directly follow a low-strobe nibble is ignored: no valid pulse, and `word_o` is unchanged.
- R4: In a run of consecutive low-strobe cycles, valid pulses after the 2nd, 4th, 6th and later even-numbered low cycles of the run, and `word_o` keeps the last completed word.
- R5: When the strobe is low on several cycles in a row, the nibble from the last low cycle is the high part of the next word.
- R6: While `tx_en_i` is low, `word_o` reads zero and valid timing is unchanged. Once enable returns high, `word_o` shows the held word again.
- R7: A synchronous active-high `rst` clears the held word to zero and drops valid. After reset, no valid (not even a repeat) is produced until a low-strobe nibble has been followed by a high-strobe nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble-rate clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| nib_i | input | 6 | Nibble bus |
| sync_i | input | 1 | Framing strobe: low = high part, high = low part |
| tx_en_i | input | 1 | Output enable; low forces `word_o` to zero |
| word_o | output | 10 | Assembled two's-complement word |
| word_vld_o | output | 1 | One-cycle word valid pulse |

## Verification
Both the assembled word and its valid pulse are registered once. They become visible directly after the rising edge that samples the completing nibble, or the repeating low cycle, so every result is due in the same cycle as its stimulus edge. The enable gate is combinational in the default build and takes effect without delay. The bench drives inputs on the falling edge, lets one rising edge pass, and compares outputs at the next falling edge. Each expected value therefore corresponds to exactly one sampled nibble.

// File: rtl/nibasm_pkg.sv
package nibasm_pkg;
   typedef enum logic {
      FR_WAIT    = 1'b0,
      FR_HAVE_HI = 1'b1
   } frame_st_t;
endpackage

// File: rtl/nibasm_frame_ctl.sv
module nibasm_frame_ctl
   import nibasm_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic sync_i,
   output logic load_hi_o,
   output logic complete_o,
   output logic repeat_o
);
   frame_st_t st_q;
   logic      ph_q;
   logic      seen_q;

   always_comb begin
      load_hi_o  = !sync_i;
      complete_o = sync_i && (st_q == FR_HAVE_HI);
      repeat_o   = !sync_i && (st_q == FR_HAVE_HI) && !ph_q && seen_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= FR_WAIT;
         ph_q   <= 1'b0;
         seen_q <= 1'b0;
      end else if (!sync_i) begin
         ph_q <= (st_q == FR_HAVE_HI) ? ~ph_q : 1'b0;
         st_q <= FR_HAVE_HI;
      end else begin
         if (st_q == FR_HAVE_HI) seen_q <= 1'b1;
         st_q <= FR_WAIT;
         ph_q <= 1'b0;
      end
   end
endmodule

// File: rtl/nibasm_word_hold.sv
module nibasm_word_hold #(
   parameter int NIB_W  = 6,
   parameter int HALF_W = 5
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NIB_W-1:0]    nib_i,
   input  logic                load_hi_i,
   input  logic                complete_i,
   input  logic                repeat_i,
   output logic [2*HALF_W-1:0] word_o,
   output logic                vld_o
);
   logic [HALF_W-1:0]   hi_q;
   logic [2*HALF_W-1:0] word_q;
   logic                vld_q;
   logic [HALF_W-1:0]   field;

   assign field = nib_i[NIB_W-1 -: HALF_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q   <= '0;
         word_q <= '0;
         vld_q  <= 1'b0;
      end else begin
         if (load_hi_i)  hi_q   <= field;
         if (complete_i) word_q <= {hi_q, field};
         vld_q <= complete_i || repeat_i;
      end
   end

   assign word_o = word_q;
   assign vld_o  = vld_q;
endmodule

// File: rtl/nibasm_out_gate.sv
module nibasm_out_gate #(
   parameter int WORD_W  = 10,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] word_o
);
   generate
      if (OUT_REG) begin : g_reg
         logic [WORD_W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= en_i ? word_i : '0;
         end
         assign word_o = q;
      end else begin : g_comb
         assign word_o = en_i ? word_i : '0;
      end
   endgenerate
endmodule

// File: rtl/nib_word_asm.sv
module nib_word_asm #(
   parameter int NIB_W   = 6,
   parameter int WORD_W  = 10,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NIB_W-1:0]  nib_i,
   input  logic              sync_i,
   input  logic              tx_en_i,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld_o
);
   localparam int HALF_W = WORD_W / 2;

   generate
      if (WORD_W % 2 != 0) begin : g_bad_even
         $error("WORD_W must be even");
      end
      if (HALF_W > NIB_W || HALF_W < 1) begin : g_bad_half
         $error("half word must fit in one nibble");
      end
   endgenerate

   logic              load_hi, complete, rep;
   logic [WORD_W-1:0] held;

   nibasm_frame_ctl u_ctl (
      .clk(clk), .rst(rst), .sync_i(sync_i),
      .load_hi_o(load_hi), .complete_o(complete), .repeat_o(rep)
   );

   nibasm_word_hold #(.NIB_W(NIB_W), .HALF_W(HALF_W)) u_hold (
      .clk(clk), .rst(rst), .nib_i(nib_i),
      .load_hi_i(load_hi), .complete_i(complete), .repeat_i(rep),
      .word_o(held), .vld_o(word_vld_o)
   );

   nibasm_out_gate #(.WORD_W(WORD_W), .OUT_REG(OUT_REG)) u_gate (
      .clk(clk), .rst(rst), .en_i(tx_en_i), .word_i(held), .word_o(word_o)
   );
endmodule

// File: rtl/nib_word_asm_chk.sv
module nib_word_asm_chk #(
   parameter int WORD_W = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              sync_i,
   input logic              tx_en_i,
   input logic [WORD_W-1:0] word_o,
   input logic              word_vld_o
);
   p_reset_clears_r7: assert property (@(posedge clk)
      rst |=> (!word_vld_o && word_o == '0));

   p_orphan_high_r3: assert property (@(posedge clk) disable iff (rst)
      (sync_i && $past(sync_i)) |=> !word_vld_o);

   p_pair_valid_r2: assert property (@(posedge clk) disable iff (rst)
      (sync_i && !$past(sync_i) && !$past(rst)) |=> word_vld_o);

   p_gate_zero_r6: assert property (@(posedge clk) disable iff (rst)
      (!tx_en_i && !$past(tx_en_i) && !$past(rst)) |-> (word_o == '0));
endmodule

bind nib_word_asm nib_word_asm_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst(rst), .sync_i(sync_i), .tx_en_i(tx_en_i),
   .word_o(word_o), .word_vld_o(word_vld_o)
);

// File: tb/nib_word_asm_test.sv
module nib_word_asm_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] nib = '0;
   logic       sync = 1'b1;
   logic       en = 1'b1;
   logic [9:0] word;
   logic       vld;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #2.5 clk = ~clk;

   nib_word_asm uut (
      .clk(clk), .rst(rst), .nib_i(nib), .sync_i(sync), .tx_en_i(en),
      .word_o(word), .word_vld_o(vld)
   );

   // {sync, nib[5:0], en, exp_vld, exp_word[9:0]}
   localparam int NV = 14;
   localparam logic [18:0] VEC [NV] = '{
      {1'b0, 6'b101011, 1'b1, 1'b0, 10'h000},  // R1 high part
      {1'b1, 6'b011000, 1'b1, 1'b1, 10'h2AC},  // R1 R2 complete
      {1'b0, 6'b000010, 1'b1, 1'b0, 10'h2AC},
      {1'b1, 6'b111111, 1'b1, 1'b1, 10'h03F},  // R1 R2
      {1'b1, 6'b010101, 1'b1, 1'b0, 10'h03F},  // R3 orphan high
      {1'b0, 6'b111110, 1'b1, 1'b0, 10'h03F},  // R4 low 1
      {1'b0, 6'b100000, 1'b1, 1'b1, 10'h03F},  // R4 low 2 repeat
      {1'b0, 6'b000000, 1'b1, 1'b0, 10'h03F},  // R4 low 3
      {1'b0, 6'b000000, 1'b1, 1'b1, 10'h03F},  // R4 low 4 repeat
      {1'b1, 6'b000001, 1'b1, 1'b1, 10'h000},  // R5 last low nibble used
      {1'b0, 6'b110011, 1'b1, 1'b0, 10'h000},
      {1'b1, 6'b001101, 1'b0, 1'b1, 10'h000},  // R6 gated, valid kept
      {1'b0, 6'b000000, 1'b1, 1'b0, 10'h326},  // R6 held word returns
      {1'b1, 6'b111101, 1'b1, 1'b1, 10'h01E}   // R1
   };

   task automatic check(input string req, input logic [9:0] ew, input logic ev);
      n_chk++;
      if (word !== ew || vld !== ev) begin
         n_fail++;
         $display("FAIL %s: word=%h vld=%b expected word=%h vld=%b",
                  req, word, vld, ew, ev);
      end
   endtask

   task automatic step(input logic s, input logic [5:0] n, input logic e);
      sync = s; nib = n; en = e;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R7", 10'h000, 1'b0);
      rst = 1'b0;
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][18], VEC[i][17:12], VEC[i][11]);
         check($sformatf("R1-vector %0d", i), VEC[i][9:0], VEC[i][10]);
      end
      // R7: reset mid-word, then a high strobe must not complete
      step(1'b0, 6'b111111, 1'b1);
      check("R7 pre", 10'h01E, 1'b0);
      rst = 1'b1;
      step(1'b0, 6'b111111, 1'b1);
      check("R7 reset", 10'h000, 1'b0);
      rst = 1'b0;
      step(1'b1, 6'b101010, 1'b1);
      check("R7 no half after reset", 10'h000, 1'b0);
      // R7: no repeat before a first completed word
      step(1'b0, 6'b011110, 1'b1);
      check("R7 low1", 10'h000, 1'b0);
      step(1'b0, 6'b010010, 1'b1);
      check("R7 no repeat", 10'h000, 1'b0);
      step(1'b1, 6'b100110, 1'b1);
      check("R5 R2 complete", 10'h133, 1'b1);
      // R3: second consecutive high ignored
      step(1'b1, 6'b111111, 1'b1);
      check("R3", 10'h133, 1'b0);
      // R6: gate low without stimulus
      step(1'b1, 6'b000000, 1'b0);
      check("R6 gated", 10'h000, 1'b0);
      step(1'b1, 6'b000000, 1'b1);
      check("R6 ungated", 10'h133, 1'b0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule